// File: doc/BRIEF.md
# Card Controller Register Front End

This block is the register-mapped face of a memory-card host controller. A processor issues word accesses into a 4 KB window, and the block answers them. It holds the setup registers: power, clock divider, command argument, command word, data timer, data length and data control. The command and data engines read these registers through dedicated outputs. The block shows the engine results (response command, four response words, remaining byte count) as read-only words. It forwards accesses in the FIFO window to the data engine's FIFO port.

A single 22-bit status word collects engine events. The low eleven positions are sticky: a one-cycle set pulse from an engine latches the bit, and it stays set until software writes a one to the clear register at that position. The upper positions are live FIFO and activity flags that follow the engine directly. Every interrupt line has its own mask register, and a line is high whenever the status word ANDed with its mask is nonzero. With the default parameters there are two lines.

Top module: `cardif_regs`

## Requirements
- R1: After reset, every setup register, the sticky status bits and all masks read as zero, and every interrupt line is low.
- R2: Power (0x00) and clock (0x04) keep only bits [7:0]. Data length (0x28) keeps [15:0] and data control (0x2C) keeps [7:0]. Argument (0x08) and data timer (0x24) keep all 32 bits. A read response carries the register value one cycle after the request.
- R3: A set pulse on sticky position k (0..10) makes status bit k read as one from the next cycle on. The bit stays set with no further pulse. Position 9 is reserved and always reads zero. Status bits [21:11] show the live flag inputs. Status is at 0x34.
- R4: A write to 0x38 clears the sticky status bits at positions where the written data bits [10:0] are one. Bits above 10 of the data have no effect. If a set pulse arrives in the same cycle as a clear, the set wins.
- R5: Interrupt line i is high while (status AND mask i) is nonzero. Mask 0 is at 0x3C and mask 1 at 0x40, and each mask acts only on its own line.
- R6: A read of 0x48 returns (remaining byte count + 3) >> 2.
- R7: A read in 0x80..0xBC pops the data-engine FIFO and returns its word. If the FIFO is empty, the read returns zero and does not pop. A write in that window pushes the data, except when the remaining byte count is zero, in which case it is dropped.
- R8: The words at 0xFE0..0xFFC read the identification bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order.
- R9: Any access is an error in these cases: a misaligned address, an unmapped offset, a read of the clear register, or a write to a read-only word. An error access reads zero, changes no state, and raises `bad_access` for one cycle, the cycle after the request.
- R10: A command write (0x0C) stores the word with bit 10 (start) cleared. When bit 10 was set, `cmd_go` pulses the next cycle. A data control write with bit 0 set pulses `data_go` the next cycle.
- R11: Offset 0x10 reads the response command input, 0x14..0x20 read response words 0..3, and 0x30 reads the remaining byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | Error pulse for the previous access |
| irq | output | 2 | Interrupt lines, one per mask |
| sts_set | input | 11 | Sticky status set pulses |
| sts_live | input | 11 | Live flags for status bits [21:11] |
| resp_cmd_i | input | 32 | Response command from the command engine |
| resp_words_i | input | 128 | Four response words, word 0 in the low bits |
| data_cnt_i | input | 16 | Remaining byte count |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO holds nothing |
| fifo_pop | output | 1 | Pop the FIFO (same cycle as the read request) |
| fifo_push | output | 1 | Push into the FIFO (same cycle as the write request) |
| fifo_wdata | output | 32 | Word to push |
| power_o | output | 8 | Power register |
| clkdiv_o | output | 8 | Clock register |
| cmd_arg_o | output | 32 | Command argument |
| cmd_word_o | output | 32 | Stored command word |
| cmd_go | output | 1 | Command start pulse |
| data_timer_o | output | 32 | Data timer |
| data_len_o | output | 16 | Data length |
| data_ctrl_o | output | 8 | Data control |
| data_go | output | 1 | Data start pulse |

## Verification
Read data, `bad_access`, `cmd_go` and `data_go` are registered, so they are due one cycle after the request edge. The bench samples them at the falling edge that follows that clock. A scoreboard queue holds each expected read word and matches it against `rsp_rdata` on the falling edge where `rsp_valid` is high. `fifo_pop` and `fifo_push` depend combinationally on the request, so they are sampled in the request cycle itself, shortly after the inputs change. Status set pulses and clears take effect at the next edge. Interrupt lines follow status and masks without a further register, so each interrupt check comes one edge after the stimulus, or after the live flag changes when the source is a live bit.

// File: rtl/cardif_regs_pkg.sv
package cardif_regs_pkg;

   // Word indices (byte offset >> 2) of the register window
   localparam int unsigned WI_PWR   = 0;
   localparam int unsigned WI_CLK   = 1;
   localparam int unsigned WI_ARG   = 2;
   localparam int unsigned WI_CMD   = 3;
   localparam int unsigned WI_RCMD  = 4;
   localparam int unsigned WI_RESP0 = 5;
   localparam int unsigned WI_RESPN = 4;
   localparam int unsigned WI_TMR   = 9;
   localparam int unsigned WI_LEN   = 10;
   localparam int unsigned WI_CTRL  = 11;
   localparam int unsigned WI_DCNT  = 12;
   localparam int unsigned WI_STAT  = 13;
   localparam int unsigned WI_CLR   = 14;
   localparam int unsigned WI_MASK0 = 15;
   localparam int unsigned WI_FCNT  = 18;
   localparam int unsigned WI_FIFO0 = 32;
   localparam int unsigned WI_FIFON = 16;
   localparam int unsigned WI_ID0   = 1016;
   localparam int unsigned WI_IDN   = 8;

   localparam int unsigned CMD_START_BIT  = 10;
   localparam int unsigned DATA_START_BIT = 0;

   typedef enum logic [4:0] {
      RG_NONE, RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_RCMD, RG_RESP,
      RG_TMR, RG_LEN, RG_CTRL, RG_DCNT, RG_STAT, RG_CLR, RG_MASK,
      RG_FCNT, RG_FIFO, RG_ID
   } region_e;

   function automatic logic [7:0] ident_byte(input logic [2:0] k);
      logic [7:0] b;
      case (k)
         3'd0:    b = 8'h81;
         3'd1:    b = 8'h11;
         3'd2:    b = 8'h04;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cardif_regs_decode.sv
module cardif_regs_decode
   import cardif_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned NUM_IRQ = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [2:0]        sub,
   output logic              rd_ok,
   output logic              wr_ok
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   generate
      if (ADDR_W != 12) begin : g_bad_aw
         $error("cardif_regs_decode: ADDR_W must be 12");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > 3) begin : g_bad_irq
         $error("cardif_regs_decode: NUM_IRQ must be 1..3");
      end
   endgenerate

   logic [31:0] wi;
   logic        aligned;

   assign wi      = 32'(addr[ADDR_W-1:2]);
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      region = RG_NONE;
      sub    = '0;
      if (!aligned)                                   region = RG_NONE;
      else if (wi == WI_PWR)                          region = RG_PWR;
      else if (wi == WI_CLK)                          region = RG_CLK;
      else if (wi == WI_ARG)                          region = RG_ARG;
      else if (wi == WI_CMD)                          region = RG_CMD;
      else if (wi == WI_RCMD)                         region = RG_RCMD;
      else if (wi >= WI_RESP0 && wi < WI_RESP0 + WI_RESPN) begin
         region = RG_RESP;
         sub    = 3'(wi - WI_RESP0);
      end
      else if (wi == WI_TMR)                          region = RG_TMR;
      else if (wi == WI_LEN)                          region = RG_LEN;
      else if (wi == WI_CTRL)                         region = RG_CTRL;
      else if (wi == WI_DCNT)                         region = RG_DCNT;
      else if (wi == WI_STAT)                         region = RG_STAT;
      else if (wi == WI_CLR)                          region = RG_CLR;
      else if (wi >= WI_MASK0 && wi < WI_MASK0 + NUM_IRQ) begin
         region = RG_MASK;
         sub    = 3'(wi - WI_MASK0);
      end
      else if (wi == WI_FCNT)                         region = RG_FCNT;
      else if (wi >= WI_FIFO0 && wi < WI_FIFO0 + WI_FIFON) region = RG_FIFO;
      else if (wi >= WI_ID0 && wi < WI_ID0 + WI_IDN) begin
         region = RG_ID;
         sub    = 3'(wi - WI_ID0);
      end
   end

   always_comb begin
      rd_ok = (region != RG_NONE) && (region != RG_CLR);
      case (region)
         RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_TMR, RG_LEN, RG_CTRL,
         RG_CLR, RG_MASK, RG_FIFO: wr_ok = 1'b1;
         default:                  wr_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/cardif_regs_status.sv
module cardif_regs_status #(
   parameter int unsigned STS_W    = 22,
   parameter int unsigned STICKY_W = 11,
   parameter int unsigned RSVD_BIT = 9,
   parameter int unsigned NUM_IRQ  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [STICKY_W-1:0]       set_i,
   input  logic [STS_W-STICKY_W-1:0] live_i,
   input  logic                      clr_we,
   input  logic [STICKY_W-1:0]       clr_val,
   input  logic [NUM_IRQ-1:0]        mask_we,
   input  logic [STS_W-1:0]          mask_val,
   output logic [STS_W-1:0]          status_o,
   output logic [NUM_IRQ*STS_W-1:0]  masks_o,
   output logic [NUM_IRQ-1:0]        irq_o
);

   localparam logic [STICKY_W-1:0] KEEP = ~(STICKY_W'(1) << RSVD_BIT);

   generate
      if (STICKY_W >= STS_W) begin : g_bad_w
         $error("cardif_regs_status: STICKY_W must be below STS_W");
      end
   endgenerate

   logic [STICKY_W-1:0] sticky_q;
   logic [STICKY_W-1:0] clr_bits;

   assign clr_bits = clr_we ? clr_val : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= ((sticky_q & ~clr_bits) | set_i) & KEEP;
   end

   assign status_o = {live_i, sticky_q};

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
         logic [STS_W-1:0] mask_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          mask_q <= '0;
            else if (mask_we[gi]) mask_q <= mask_val;
         end
         assign masks_o[gi*STS_W +: STS_W] = mask_q;
         assign irq_o[gi] = |(status_o & mask_q);
      end
   endgenerate

endmodule

// File: rtl/cardif_regs_cfg.sv
module cardif_regs_cfg
   import cardif_regs_pkg::*;
#(
   parameter int unsigned DW             = 32,
   parameter int unsigned PWR_W          = 8,
   parameter int unsigned CLK_W          = 8,
   parameter int unsigned LEN_W          = 16,
   parameter int unsigned CTRL_W         = 8,
   parameter bit          CMD_SELF_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  region_e           region,
   input  logic [DW-1:0]     wdata,
   output logic [PWR_W-1:0]  power_q,
   output logic [CLK_W-1:0]  clk_q,
   output logic [DW-1:0]     arg_q,
   output logic [DW-1:0]     cmd_q,
   output logic [DW-1:0]     tmr_q,
   output logic [LEN_W-1:0]  len_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              cmd_go,
   output logic              data_go
);

   generate
      if (PWR_W > DW || CLK_W > DW || LEN_W > DW || CTRL_W > DW) begin : g_bad_w
         $error("cardif_regs_cfg: field wider than data bus");
      end
   endgenerate

   logic [DW-1:0] cmd_store;

   generate
      if (CMD_SELF_CLEAR) begin : g_selfclr
         assign cmd_store = wdata & ~(DW'(1) << CMD_START_BIT);
      end else begin : g_keep
         assign cmd_store = wdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         power_q <= '0;
         clk_q   <= '0;
         arg_q   <= '0;
         cmd_q   <= '0;
         tmr_q   <= '0;
         len_q   <= '0;
         ctrl_q  <= '0;
         cmd_go  <= 1'b0;
         data_go <= 1'b0;
      end else begin
         cmd_go  <= we && (region == RG_CMD)  && wdata[CMD_START_BIT];
         data_go <= we && (region == RG_CTRL) && wdata[DATA_START_BIT];
         if (we) begin
            case (region)
               RG_PWR:  power_q <= wdata[PWR_W-1:0];
               RG_CLK:  clk_q   <= wdata[CLK_W-1:0];
               RG_ARG:  arg_q   <= wdata;
               RG_CMD:  cmd_q   <= cmd_store;
               RG_TMR:  tmr_q   <= wdata;
               RG_LEN:  len_q   <= wdata[LEN_W-1:0];
               RG_CTRL: ctrl_q  <= wdata[CTRL_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cardif_regs.sv
module cardif_regs
   import cardif_regs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DW       = 32,
   parameter int unsigned STS_W    = 22,
   parameter int unsigned STICKY_W = 11,
   parameter int unsigned NUM_IRQ  = 2,
   parameter int unsigned LEN_W    = 16,
   parameter int unsigned BYTE_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DW-1:0]             req_wdata,
   output logic                      rsp_valid,
   output logic [DW-1:0]             rsp_rdata,
   output logic                      bad_access,
   output logic [NUM_IRQ-1:0]        irq,
   input  logic [STICKY_W-1:0]       sts_set,
   input  logic [STS_W-STICKY_W-1:0] sts_live,
   input  logic [DW-1:0]             resp_cmd_i,
   input  logic [4*DW-1:0]           resp_words_i,
   input  logic [LEN_W-1:0]          data_cnt_i,
   input  logic [DW-1:0]             fifo_rdata,
   input  logic                      fifo_empty,
   output logic                      fifo_pop,
   output logic                      fifo_push,
   output logic [DW-1:0]             fifo_wdata,
   output logic [BYTE_W-1:0]         power_o,
   output logic [BYTE_W-1:0]         clkdiv_o,
   output logic [DW-1:0]             cmd_arg_o,
   output logic [DW-1:0]             cmd_word_o,
   output logic                      cmd_go,
   output logic [DW-1:0]             data_timer_o,
   output logic [LEN_W-1:0]          data_len_o,
   output logic [BYTE_W-1:0]         data_ctrl_o,
   output logic                      data_go
);

   localparam int unsigned RSVD_BIT = 9;

   generate
      if (STS_W > DW) begin : g_bad_sts
         $error("cardif_regs: status wider than data bus");
      end
      if (STICKY_W <= RSVD_BIT) begin : g_bad_sticky
         $error("cardif_regs: STICKY_W must cover the reserved bit");
      end
   endgenerate

   region_e     region;
   logic [2:0]  sub;
   logic        rd_ok, wr_ok;
   logic        wr_fire, rd_fire, err_now;
   logic [STS_W-1:0]         status_w;
   logic [NUM_IRQ*STS_W-1:0] masks_w;
   logic [NUM_IRQ-1:0]       mask_we;
   logic [DW-1:0]            rd_mux;

   cardif_regs_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_dec (
      .addr   (req_addr),
      .region (region),
      .sub    (sub),
      .rd_ok  (rd_ok),
      .wr_ok  (wr_ok)
   );

   assign wr_fire = req_valid &&  req_write && wr_ok;
   assign rd_fire = req_valid && !req_write && rd_ok;
   assign err_now = req_valid && (req_write ? !wr_ok : !rd_ok);

   always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) begin
         mask_we[i] = wr_fire && (region == RG_MASK) && (32'(sub) == i);
      end
   end

   cardif_regs_cfg #(
      .DW(DW), .PWR_W(BYTE_W), .CLK_W(BYTE_W), .LEN_W(LEN_W),
      .CTRL_W(BYTE_W), .CMD_SELF_CLEAR(1'b1)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_fire),
      .region  (region),
      .wdata   (req_wdata),
      .power_q (power_o),
      .clk_q   (clkdiv_o),
      .arg_q   (cmd_arg_o),
      .cmd_q   (cmd_word_o),
      .tmr_q   (data_timer_o),
      .len_q   (data_len_o),
      .ctrl_q  (data_ctrl_o),
      .cmd_go  (cmd_go),
      .data_go (data_go)
   );

   cardif_regs_status #(
      .STS_W(STS_W), .STICKY_W(STICKY_W), .RSVD_BIT(RSVD_BIT), .NUM_IRQ(NUM_IRQ)
   ) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (sts_set),
      .live_i   (sts_live),
      .clr_we   (wr_fire && (region == RG_CLR)),
      .clr_val  (req_wdata[STICKY_W-1:0]),
      .mask_we  (mask_we),
      .mask_val (req_wdata[STS_W-1:0]),
      .status_o (status_w),
      .masks_o  (masks_w),
      .irq_o    (irq)
   );

   assign fifo_pop   = rd_fire && (region == RG_FIFO) && !fifo_empty;
   assign fifo_push  = wr_fire && (region == RG_FIFO) && (data_cnt_i != '0);
   assign fifo_wdata = req_wdata;

   always_comb begin
      rd_mux = '0;
      case (region)
         RG_PWR:  rd_mux = DW'(power_o);
         RG_CLK:  rd_mux = DW'(clkdiv_o);
         RG_ARG:  rd_mux = cmd_arg_o;
         RG_CMD:  rd_mux = cmd_word_o;
         RG_RCMD: rd_mux = resp_cmd_i;
         RG_RESP: rd_mux = resp_words_i[32'(sub)*DW +: DW];
         RG_TMR:  rd_mux = data_timer_o;
         RG_LEN:  rd_mux = DW'(data_len_o);
         RG_CTRL: rd_mux = DW'(data_ctrl_o);
         RG_DCNT: rd_mux = DW'(data_cnt_i);
         RG_STAT: rd_mux = DW'(status_w);
         RG_MASK: begin
            for (int i = 0; i < NUM_IRQ; i++) begin
               if (32'(sub) == i) rd_mux = DW'(masks_w[i*STS_W +: STS_W]);
            end
         end
         RG_FCNT: rd_mux = DW'((32'(data_cnt_i) + 32'd3) >> 2);
         RG_FIFO: rd_mux = fifo_empty ? '0 : fifo_rdata;
         RG_ID:   rd_mux = DW'(ident_byte(sub));
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         bad_access <= 1'b0;
      end else begin
         rsp_valid  <= req_valid && !req_write;
         rsp_rdata  <= rd_fire ? rd_mux : '0;
         bad_access <= err_now;
      end
   end

endmodule

// File: rtl/cardif_regs_chk.sv
module cardif_regs_chk #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DW       = 32,
   parameter int unsigned STS_W    = 22,
   parameter int unsigned STICKY_W = 11,
   parameter int unsigned NUM_IRQ  = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [ADDR_W-1:0]     req_addr,
   input logic [DW-1:0]         req_wdata,
   input logic                  rsp_valid,
   input logic                  bad_access,
   input logic [NUM_IRQ-1:0]    irq,
   input logic [STICKY_W-1:0]   sts_set,
   input logic [STS_W-1:0]      status_w,
   input logic                  fifo_pop,
   input logic                  fifo_push,
   input logic                  fifo_empty
);

   localparam logic [STICKY_W-1:0] KEEP = ~(STICKY_W'(1) << 9);

   logic clr_hit;
   assign clr_hit = req_valid && req_write && (req_addr == ADDR_W'(12'h038));

   // R3: a set pulse lands in the status word at the next edge
   a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_set & KEEP) != '0) |=>
         ((status_w[STICKY_W-1:0] & $past(sts_set & KEEP)) == $past(sts_set & KEEP)));

   // R3: without a clear write no sticky bit falls
   a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hit |=> ((~status_w[STICKY_W-1:0] & $past(status_w[STICKY_W-1:0])) == '0));

   // R4: a clear with no coincident set removes the selected bits
   a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && sts_set == '0) |=>
         ((status_w[STICKY_W-1:0] & $past(req_wdata[STICKY_W-1:0])) == '0));

   // R5: no interrupt without some status bit
   a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |-> (status_w != '0));

   // R9: an error pulse only follows a request
   a_r9_err_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(req_valid));

   // R2: read data is only presented for a read request
   a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   // R7: never pop an empty FIFO, never pop and push together
   a_r7_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (!fifo_empty && !fifo_push));

endmodule

bind cardif_regs cardif_regs_chk #(
   .ADDR_W(ADDR_W), .DW(DW), .STS_W(STS_W), .STICKY_W(STICKY_W), .NUM_IRQ(NUM_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .rsp_valid  (rsp_valid),
   .bad_access (bad_access),
   .irq        (irq),
   .sts_set    (sts_set),
   .status_w   (status_w),
   .fifo_pop   (fifo_pop),
   .fifo_push  (fifo_push),
   .fifo_empty (fifo_empty)
);

// File: tb/cardif_regs_test.sv
module cardif_regs_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid, bad_access, fifo_pop, fifo_push, cmd_go, data_go;
   logic [31:0] rsp_rdata, fifo_wdata, cmd_arg_o, cmd_word_o, data_timer_o;
   logic [1:0] irq;
   logic [10:0] sts_set = '0, sts_live = '0;
   logic [31:0] resp_cmd_i = '0, fifo_rdata = '0;
   logic [127:0] resp_words_i = '0;
   logic [15:0] data_cnt_i = '0, data_len_o;
   logic fifo_empty = 1'b1;
   logic [7:0] power_o, clkdiv_o, data_ctrl_o;

   int n_checks = 0, n_errors = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];
   logic seen_push, seen_pop;

   always #(CLK_PERIOD/2) clk = ~clk;

   cardif_regs uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .bad_access(bad_access), .irq(irq),
      .sts_set(sts_set), .sts_live(sts_live), .resp_cmd_i(resp_cmd_i),
      .resp_words_i(resp_words_i), .data_cnt_i(data_cnt_i),
      .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
      .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .power_o(power_o),
      .clkdiv_o(clkdiv_o), .cmd_arg_o(cmd_arg_o), .cmd_word_o(cmd_word_o),
      .cmd_go(cmd_go), .data_timer_o(data_timer_o), .data_len_o(data_len_o),
      .data_ctrl_o(data_ctrl_o), .data_go(data_go)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare read responses against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("unexpected response", rsp_rdata, 32'hxxxx_xxxx);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rsp_rdata, e);
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      #1 seen_pop = fifo_pop;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wr_set(input logic [11:0] a, input logic [31:0] d, input logic [10:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; sts_set = s;
      #1 seen_push = fifo_push;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; sts_set = '0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_set(a, d, 11'h0);
   endtask

   task automatic pulse(input logic [10:0] s);
      @(negedge clk);
      sts_set = s;
      @(negedge clk);
      sts_set = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      rd(12'h000, 0, "R1 power"); rd(12'h008, 0, "R1 arg");
      rd(12'h034, 0, "R1 status"); rd(12'h03C, 0, "R1 mask0");
      rd(12'h040, 0, "R1 mask1"); rd(12'h02C, 0, "R1 ctrl");

      // R2 setup registers and widths
      wr(12'h000, 32'h1234_56A5); rd(12'h000, 32'hA5, "R2 power");
      wr(12'h004, 32'hFFFF_FF3C); rd(12'h004, 32'h3C, "R2 clock");
      wr(12'h008, 32'hDEAD_BEEF); rd(12'h008, 32'hDEAD_BEEF, "R2 arg");
      wr(12'h024, 32'h0BAD_F00D); rd(12'h024, 32'h0BAD_F00D, "R2 timer");
      wr(12'h028, 32'h0012_3456); rd(12'h028, 32'h3456, "R2 length");
      wr(12'h02C, 32'h0000_01FE);
      check("R10 data_go idle", 32'(data_go), 0);
      rd(12'h02C, 32'hFE, "R2 ctrl");

      // R10 command and data start
      wr(12'h00C, 32'h0000_0451);
      check("R10 cmd_go", 32'(cmd_go), 1);
      rd(12'h00C, 32'h51, "R10 cmd stored");
      wr(12'h00C, 32'h0000_0012);
      check("R10 cmd_go idle", 32'(cmd_go), 0);
      rd(12'h00C, 32'h12, "R10 cmd plain");
      wr(12'h02C, 32'h0000_0003);
      check("R10 data_go", 32'(data_go), 1);

      // R3 sticky and live status
      pulse(11'h241);
      rd(12'h034, 32'h41, "R3 set reserved");
      rd(12'h034, 32'h41, "R3 held");
      sts_live = 11'h005;
      rd(12'h034, 32'h2841, "R3 live");

      // R4 clear
      wr(12'h038, 32'hFFFF_F040);
      rd(12'h034, 32'h2801, "R4 clear bit6");
      wr_set(12'h038, 32'h1, 11'h001);
      rd(12'h034, 32'h2801, "R4 set wins");
      wr(12'h038, 32'h1);
      rd(12'h034, 32'h2800, "R4 clear bit0");
      sts_live = '0;
      rd(12'h034, 32'h0, "R4 all clear");

      // R5 interrupts
      pulse(11'h004);
      check("R5 masked off", 32'(irq), 0);
      wr(12'h03C, 32'h4);  check("R5 line0", 32'(irq), 1);
      wr(12'h040, 32'h8);  check("R5 line1 idle", 32'(irq), 1);
      pulse(11'h008);      check("R5 both", 32'(irq), 3);
      wr(12'h038, 32'h4);  check("R5 after clear", 32'(irq), 2);
      wr(12'h040, 32'h0);  check("R5 unmask", 32'(irq), 0);
      rd(12'h03C, 32'h4, "R5 mask0 read");
      wr(12'h03C, 32'h1000);
      @(negedge clk); sts_live = 11'h002; #1;
      check("R5 live bit", 32'(irq), 1);
      sts_live = '0;
      wr(12'h038, 32'h8);

      // R6 FIFO word count
      data_cnt_i = 0;      rd(12'h048, 0, "R6 zero");
      data_cnt_i = 1;      rd(12'h048, 1, "R6 one");
      data_cnt_i = 4;      rd(12'h048, 1, "R6 four");
      data_cnt_i = 5;      rd(12'h048, 2, "R6 five");
      data_cnt_i = 16'hFFFF; rd(12'h048, 32'h4000, "R6 max");

      // R11 engine values
      resp_cmd_i = 32'h2A;
      resp_words_i = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
      rd(12'h010, 32'h2A, "R11 respcmd");
      rd(12'h014, 32'h1111_1111, "R11 resp0");
      rd(12'h020, 32'h4444_4444, "R11 resp3");
      rd(12'h030, 32'hFFFF, "R11 count");

      // R7 FIFO window
      fifo_empty = 1'b1; fifo_rdata = 32'hCAFE_F00D;
      rd(12'h080, 0, "R7 empty read");
      check("R7 no pop", 32'(seen_pop), 0);
      fifo_empty = 1'b0;
      rd(12'h0BC, 32'hCAFE_F00D, "R7 pop read");
      check("R7 pop", 32'(seen_pop), 1);
      data_cnt_i = 0;
      wr(12'h084, 32'h5555_AAAA);
      check("R7 drop", 32'(seen_push), 0);
      data_cnt_i = 8;
      wr(12'h084, 32'h5555_AAAA);
      check("R7 push", 32'(seen_push), 1);
      fifo_empty = 1'b1;

      // R8 identification
      begin
         logic [7:0] idv [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
         for (int k = 0; k < 8; k++)
            rd(12'hFE0 + 12'(4*k), 32'(idv[k]), $sformatf("R8 id%0d", k));
      end

      // R9 error accesses
      rd(12'h044, 0, "R9 hole read");      check("R9 err hole", 32'(bad_access), 1);
      rd(12'h038, 0, "R9 clear read");     check("R9 err clr", 32'(bad_access), 1);
      rd(12'h002, 0, "R9 misaligned");     check("R9 err misal", 32'(bad_access), 1);
      wr(12'h010, 32'h1);                  check("R9 err ro", 32'(bad_access), 1);
      wr(12'h001, 32'h77);                 check("R9 err wmisal", 32'(bad_access), 1);
      rd(12'h000, 32'hA5, "R9 power kept"); check("R9 ok access", 32'(bad_access), 0);

      repeat (3) @(negedge clk);
      check("scoreboard drained", 32'(exp_q.size()), 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule